// File: doc/BRIEF.md
# Cascadable 4-bit Up/Down Counter

This block is a four-bit binary counter. It steps by one on each rising clock edge, either up or down. Two asynchronous active-high controls act on the count without waiting for the clock. A clear control forces the count to zero. A load control copies a four-bit preset word into the count. While either control is held high, the clock has no effect on the count.

An active-low carry input enables counting. While it is high, the count holds its value. An active-low carry output is formed combinationally from the count, the direction and the carry input. It marks terminal count and drives the carry input of the next stage. Stages joined this way form wider counters that all share one clock, and a carry ripples through the whole chain within the same cycle.

Top module: `cascade_updown4`

## Requirements
- R1: When `count_up` is 1 and `cin_n` is 0, a rising edge of `clk` raises `q` by one. Bit 0 of `q` is the least significant bit.
- R2: When `count_up` is 0 and `cin_n` is 0, a rising edge of `clk` lowers `q` by one.
- R3: Raising `rst` forces `q` to 0 at once, without a clock edge. While `rst` stays high, clock edges leave `q` at 0.
- R4: While `load_en` is high and `rst` is low, `q` follows `preset`, including changes of `preset` that arrive between clock edges. Clock edges have no effect during this time.
- R5: When `rst` and `load_en` are both high, `q` is 0.
- R6: While `cin_n` is 1, clock edges leave `q` unchanged.
- R7: `cout_n` is 0 exactly when `cin_n` is 0 and one of these holds: `count_up` is 1 and `q` is 15, or `count_up` is 0 and `q` is 0. Otherwise `cout_n` is 1.
- R8: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R9: Two stages, where the `cout_n` of the low stage drives the `cin_n` of the high stage, count as one 8-bit up/down counter with wrap-around. The `cout_n` of the high stage is 0 only at the 8-bit terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high, blocks the clock |
| load_en | input | 1 | Asynchronous load of `preset`, active high, blocks the clock |
| preset | input | 4 | Parallel load value |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n | input | 1 | Count enable, active low |
| q | output | 4 | Count value, bit 0 is the LSB |
| cout_n | output | 1 | Terminal-count carry, active low |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, clear and load can be high together. In the second pair, a carry can ripple from the low stage into the high stage on the same edge at which the low stage wraps. The bench raises clear and load together and expects zero. It also drives random direction and enable patterns through a two-stage 8-bit chain across the 0x0F/0x10 and 0xFF/0x00 boundaries. Each result is compared with an 8-bit reference value, and the high stage's carry is compared with the 8-bit terminal count.

// File: rtl/cascade_updown4.sv
module cascade_updown4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] preset,
  input  logic         count_up,
  input  logic         cin_n,
  output logic [W-1:0] q,
  output logic         cout_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic run;
  assign run = ~cin_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic set_b, clr_b, tog_b, q_r;
    assign clr_b = rst | (load_en & ~preset[i]);
    assign set_b = ~rst & load_en & preset[i];
    if (i == 0) begin : g_lsb
      assign tog_b = run;
    end else begin : g_up
      assign tog_b = run & (count_up ? &q[i-1:0] : ~|q[i-1:0]);
    end
    always_ff @(posedge clk or posedge clr_b or posedge set_b) begin
      if (clr_b)      q_r <= 1'b0;
      else if (set_b) q_r <= 1'b1;
      else if (tog_b) q_r <= ~q_r;
    end
    assign q[i] = q_r;
  end

  assign cout_n = ~(run & (count_up ? (q == TOP) : (q == '0)));

  AST_CLEAR_HOLDS: assert property (@(posedge clk) rst |-> q == '0); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst || load_en)
    (!rst && !load_en && !cin_n && count_up) |=> q == $past(q) + 1'b1); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst || load_en)
    (!rst && !load_en && !cin_n && !count_up) |=> q == $past(q) - 1'b1); // R2
  AST_INHIBIT: assert property (@(posedge clk) disable iff (rst || load_en)
    (!rst && !load_en && cin_n) |=> $stable(q)); // R6
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst || load_en)
    (!rst && !load_en && !cout_n && count_up) |=> q == '0); // R8
  AST_LOAD_TRACK: assert property (@(posedge clk) (load_en && !rst) |-> q == preset); // R4
endmodule

// File: tb/test_cascade_updown4.sv
module test_cascade_updown4;
  logic clk = 0, rst = 0, load_en = 0, count_up = 1, cin_n = 0;
  logic [7:0] pre8 = 0;
  logic [3:0] q_lo, q_hi;
  logic cout_lo, cout_hi;
  int checks = 0, fails = 0;
  logic [7:0] ref8;

  always #5 clk = ~clk;

  cascade_updown4 i_cascade_updown4 (.clk(clk), .rst(rst), .load_en(load_en), .preset(pre8[3:0]),
    .count_up(count_up), .cin_n(cin_n), .q(q_lo), .cout_n(cout_lo));
  cascade_updown4 i_hi (.clk(clk), .rst(rst), .load_en(load_en), .preset(pre8[7:4]),
    .count_up(count_up), .cin_n(cout_lo), .q(q_hi), .cout_n(cout_hi));

  function automatic logic exp_cout(input logic en_n, input logic up, input logic [7:0] v, input logic [7:0] term_up);
    return ~(~en_n & (up ? (v == term_up) : (v == 8'd0)));
  endfunction

  function automatic logic [7:0] next8(input logic [7:0] v, input logic up, input logic en_n);
    if (en_n) return v;
    return up ? v + 8'd1 : v - 8'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check_all(input string req);
    chk(req, {q_hi, q_lo}, ref8);
    chk("R7", cout_lo, exp_cout(cin_n, count_up, {4'd0, q_lo}, 8'h0F));
    chk("R9", cout_hi, exp_cout(cin_n, count_up, ref8, 8'hFF));
  endtask

  initial begin
    fork
      begin #1_500_000; fails++; $display("FAIL watchdog expired actual=running expected=done"); end
      begin
        #1 rst = 1;
        #2 chk("R3", {q_hi, q_lo}, 0);
        tick(); tick(); chk("R3", {q_hi, q_lo}, 0);
        rst = 0; ref8 = 0; cin_n = 0; count_up = 1;
        #1 check_all("R7");
        tick(); ref8 = 1; check_all("R1");
        // load 0x0E, count up through the nibble carry
        pre8 = 8'h0E; load_en = 1; #1 chk("R4", {q_hi, q_lo}, 8'h0E);
        pre8 = 8'h3C; #1 chk("R4", {q_hi, q_lo}, 8'h3C);
        tick(); chk("R4", {q_hi, q_lo}, 8'h3C);
        pre8 = 8'h0E; #1 chk("R4", {q_hi, q_lo}, 8'h0E);
        load_en = 0; ref8 = 8'h0E;
        for (int k = 0; k < 3; k++) begin tick(); ref8 = ref8 + 1; check_all("R1"); end
        count_up = 0; #1 check_all("R7");
        for (int k = 0; k < 3; k++) begin tick(); ref8 = ref8 - 1; check_all("R2"); end
        // inhibit
        cin_n = 1; #1 check_all("R7");
        tick(); tick(); check_all("R6");
        cin_n = 0;
        // 8-bit wrap both ways
        pre8 = 8'h01; load_en = 1; tick(); load_en = 0; ref8 = 8'h01; count_up = 0;
        for (int k = 0; k < 3; k++) begin tick(); ref8 = ref8 - 1; check_all("R8"); end
        count_up = 1;
        for (int k = 0; k < 3; k++) begin tick(); ref8 = ref8 + 1; check_all("R8"); end
        // clear beats load
        pre8 = 8'hA5; load_en = 1; rst = 1; #1 chk("R5", {q_hi, q_lo}, 0);
        tick(); chk("R5", {q_hi, q_lo}, 0);
        rst = 0; #1 chk("R4", {q_hi, q_lo}, 8'hA5);
        tick(); load_en = 0; ref8 = 8'hA5;
        // random run
        void'($urandom(32'd1234));
        for (int n = 0; n < 2000; n++) begin
          int r;
          r = $urandom_range(0, 99);
          count_up = $urandom_range(0, 1);
          cin_n = ($urandom_range(0, 3) == 0);
          if (r < 3) begin
            pre8 = $urandom; load_en = 1; tick(); load_en = 0; ref8 = pre8;
            check_all("R4");
          end else if (r < 5) begin
            rst = 1; tick(); rst = 0; ref8 = 0;
            check_all("R3");
          end else begin
            #1 check_all("R9");
            tick(); ref8 = next8(ref8, count_up, cin_n);
            check_all("R9");
          end
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule